// File: doc/BRIEF.md
# Floating-Point Status Register Update Unit

This block owns the 32-bit floating-point status and control word of a processor core. It updates the word once per completed floating-point instruction. An external arithmetic unit reports that instruction's exception conditions on a single update strobe: overflow, underflow, divide-by-zero, inexact, fraction-rounded and fraction-inexact flags, a vector of invalid-operation cause bits, and an optional result-class code. The unit folds these into the word under mixed sticky and overwrite rules. In the same clock it recomputes the two summary bits: the invalid summary and the enabled-exception summary.

When the instruction asks for a record, the unit publishes the top nibble of the new word as a 4-bit condition field with a one-cycle valid pulse. If the enabled-exception summary is set and either machine-state exception-mode bit is nonzero, it raises a one-cycle interrupt request. A full-word load port lets surrounding logic place any value in the word, including the enable bits. The load takes priority over an update in the same cycle.

Bit map, from bit 31 down: 31 exception summary (XS), 30 enabled-exception summary (ES), 29 invalid summary (IS), 28 overflow (OV), 27 underflow (UN), 26 divide-by-zero (DZ), 25 inexact (IX), 24:19 invalid causes, 18 fraction-rounded (RD), 17 fraction-inexact (FI), 16:12 result class (bit 16 class bit, 15:12 condition code), 11:8 and 2:0 held unchanged by updates, 7 invalid enable, 6 overflow enable, 5 underflow enable, 4 divide-by-zero enable, 3 inexact enable.

Top module: `fpsu_status_unit`

## Requirements
- R1: During and right after reset the status word equals RESET_VAL (default 0), and the condition field, its valid pulse and the interrupt request are all 0.
- R2: On an update, OV, UN and DZ (bits 28, 27, 26) are each set when their condition is 1 and cleared when it is 0. A set condition also sets XS (bit 31). XS is never cleared by an update.
- R3: On an update with inexact = 1, IX (bit 25) and XS are set. With inexact = 0, IX keeps its value.
- R4: On an update, RD (bit 18) and FI (bit 17) take their condition values directly. FI = 1 alone does not set IX.
- R5: On an update, the invalid cause vector is ORed into bits 24:19, and XS is set when the vector is nonzero.
- R6: After every update, IS (bit 29) is 1 exactly when some bit of 24:19 is 1.
- R7: After every update, ES (bit 30) equals (IS&bit7)|(OV&bit6)|(UN&bit5)|(DZ&bit4)|(IX&bit3), computed from the new values.
- R8: On an update with record = 1, the condition field output takes the new bits 31:28 and its valid pulse is 1 for one cycle. Without record, the field holds its value.
- R9: One cycle after an update, the interrupt request is 1 exactly when the new ES is 1 and either mode input is 1. Otherwise it is 0.
- R10: With the class write enable, bits 16:12 are replaced by the supplied 5-bit code. With only the condition-code write enable, just bits 15:12 change. The class write wins when both are given.
- R11: A load writes the supplied 32-bit word verbatim on the next edge and overrides a simultaneous update.
- R12: With neither update nor load, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | One instruction's conditions are present |
| cond_ovf | input | 1 | Overflow condition |
| cond_unf | input | 1 | Underflow condition |
| cond_zdiv | input | 1 | Divide-by-zero condition |
| cond_inexact | input | 1 | Inexact condition |
| cond_rnd | input | 1 | Fraction-rounded condition |
| cond_finx | input | 1 | Fraction-inexact condition |
| inv_cause | input | 6 | Invalid-operation cause bits for 24:19 |
| class_we | input | 1 | Replace the whole result-class field |
| class_val | input | 5 | New result-class code |
| cc_we | input | 1 | Replace only the 4-bit condition code |
| cc_val | input | 4 | New condition code |
| record | input | 1 | Publish the condition field |
| exc_mode | input | 2 | Machine-state exception-mode bits |
| ld_en | input | 1 | Load the whole word |
| ld_val | input | 32 | Word to load |
| status_q | output | 32 | Current status and control word |
| crf_q | output | 4 | Published condition field |
| crf_valid | output | 1 | Condition field written this cycle |
| irq_req | output | 1 | Enabled-exception interrupt request |

## Verification
The hardest state to reach is one where a summary bit disagrees with the new exception bits. Two examples are an IS bit left set when no invalid cause is present, and an enabled exception that is flagged while the mode bits are both clear. Such a state cannot arise from updates alone. The stimulus uses the load port to plant these inconsistent and sticky starting words before each table vector. The following update must then repair or keep each bit according to its own rule.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;

    // Word geometry
    localparam int SR_W   = 32;
    localparam int INV_W  = 6;
    localparam int CLS_W  = 5;
    localparam int CC_W   = 4;
    localparam int CRF_W  = 4;
    localparam int MODE_W = 2;
    localparam int SC_N   = 3;   // set/clear exception bits

    // Bit positions (top nibble order is published to the condition field)
    localparam int P_XS     = 31;
    localparam int P_ES     = 30;
    localparam int P_IS     = 29;
    localparam int P_OV     = 28;
    localparam int P_UN     = 27;
    localparam int P_DZ     = 26;
    localparam int P_IX     = 25;
    localparam int INV_HI   = P_IX - 1;
    localparam int INV_LO   = INV_HI - INV_W + 1;
    localparam int P_RD     = INV_LO - 1;
    localparam int P_FI     = P_RD - 1;
    localparam int CLS_HI   = P_FI - 1;
    localparam int CLS_LO   = CLS_HI - CLS_W + 1;
    localparam int CC_LO    = CLS_LO;
    localparam int CRF_LO   = P_XS - CRF_W + 1;
    localparam int P_EN_IS  = 7;
    localparam int P_EN_OV  = 6;
    localparam int P_EN_UN  = 5;
    localparam int P_EN_DZ  = 4;
    localparam int P_EN_IX  = 3;

    typedef logic [SR_W-1:0] sr_t;

    typedef struct packed {
        logic [SC_N-1:0]  sc;       // {ovf, unf, zdiv}
        logic             inexact;
        logic             rnd;
        logic             finx;
        logic [INV_W-1:0] inv;
    } fp_cond_t;

    typedef struct packed {
        logic             cls_we;
        logic [CLS_W-1:0] cls_val;
        logic             cc_we;
        logic [CC_W-1:0]  cc_val;
    } fp_class_t;

    // Position of the i-th set/clear exception bit, MSB first
    function automatic int sc_pos(input int i);
        return P_OV - i;
    endfunction

    // Enable-gated OR chain over the five exception sources
    function automatic logic enabled_exc(input sr_t s);
        return (s[P_IS] & s[P_EN_IS]) |
               (s[P_OV] & s[P_EN_OV]) |
               (s[P_UN] & s[P_EN_UN]) |
               (s[P_DZ] & s[P_EN_DZ]) |
               (s[P_IX] & s[P_EN_IX]);
    endfunction

endpackage

// File: rtl/fpsu_bits.sv
module fpsu_bits
    import fpsu_pkg::*;
(
    input  sr_t       sr_cur,
    input  fp_cond_t  cond,
    input  fp_class_t cls,
    output sr_t       sr_bits
);

    always_comb begin
        sr_bits = sr_cur;
        // set/clear exception bits: follow the condition, set XS when raised
        for (int i = 0; i < SC_N; i++) begin
            if (cond.sc[SC_N-1-i]) begin
                sr_bits[sc_pos(i)] = 1'b1;
                sr_bits[P_XS]      = 1'b1;
            end else begin
                sr_bits[sc_pos(i)] = 1'b0;
            end
        end
        // inexact is sticky
        if (cond.inexact) begin
            sr_bits[P_IX] = 1'b1;
            sr_bits[P_XS] = 1'b1;
        end
        // fraction flags are overwritten, never touch IX
        sr_bits[P_RD] = cond.rnd;
        sr_bits[P_FI] = cond.finx;
        // invalid causes accumulate
        sr_bits[INV_HI:INV_LO] = sr_cur[INV_HI:INV_LO] | cond.inv;
        if (|cond.inv) begin
            sr_bits[P_XS] = 1'b1;
        end
        // result class: whole field wins over the condition-code subfield
        if (cls.cls_we) begin
            sr_bits[CLS_HI:CLS_LO] = cls.cls_val;
        end else if (cls.cc_we) begin
            sr_bits[CC_LO+CC_W-1:CC_LO] = cls.cc_val;
        end
    end

endmodule

// File: rtl/fpsu_summary.sv
module fpsu_summary
    import fpsu_pkg::*;
(
    input  sr_t sr_bits,
    output sr_t sr_next
);

    logic is_new;
    sr_t  with_is;

    always_comb begin
        is_new          = |sr_bits[INV_HI:INV_LO];
        with_is         = sr_bits;
        with_is[P_IS]   = is_new;
        sr_next         = with_is;
        sr_next[P_ES]   = enabled_exc(with_is);
    end

endmodule

// File: rtl/fpsu_report.sv
module fpsu_report
    import fpsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              record,
    input  logic [MODE_W-1:0] mode,
    input  logic [CRF_W-1:0]  top_next,
    input  logic              es_next,
    output logic [CRF_W-1:0]  crf_q,
    output logic              crf_valid,
    output logic              irq_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            crf_q     <= '0;
            crf_valid <= 1'b0;
            irq_req   <= 1'b0;
        end else begin
            crf_valid <= upd & record;
            if (upd & record) begin
                crf_q <= top_next;
            end
            irq_req <= upd & es_next & (|mode);
        end
    end

    // R8: field holds without a recorded update
    p_crf_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(upd && record) |=> $stable(crf_q));

    // R9: no request when both mode bits are clear
    p_irq_mode_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == '0) |=> !irq_req);

endmodule

// File: rtl/fpsu_status_unit.sv
module fpsu_status_unit
    import fpsu_pkg::*;
#(
    parameter logic [SR_W-1:0] RESET_VAL = '0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic              cond_ovf,
    input  logic              cond_unf,
    input  logic              cond_zdiv,
    input  logic              cond_inexact,
    input  logic              cond_rnd,
    input  logic              cond_finx,
    input  logic [INV_W-1:0]  inv_cause,
    input  logic              class_we,
    input  logic [CLS_W-1:0]  class_val,
    input  logic              cc_we,
    input  logic [CC_W-1:0]   cc_val,
    input  logic              record,
    input  logic [MODE_W-1:0] exc_mode,
    input  logic              ld_en,
    input  logic [SR_W-1:0]   ld_val,
    output logic [SR_W-1:0]   status_q,
    output logic [CRF_W-1:0]  crf_q,
    output logic              crf_valid,
    output logic              irq_req
);

    fp_cond_t  cond;
    fp_class_t cls;
    sr_t       sr_bits;
    sr_t       sr_next;
    logic      upd;

    assign cond = '{sc: {cond_ovf, cond_unf, cond_zdiv}, inexact: cond_inexact,
                    rnd: cond_rnd, finx: cond_finx, inv: inv_cause};
    assign cls  = '{cls_we: class_we, cls_val: class_val,
                    cc_we: cc_we, cc_val: cc_val};
    assign upd  = upd_valid & ~ld_en;

    fpsu_bits u_bits (
        .sr_cur  (status_q),
        .cond    (cond),
        .cls     (cls),
        .sr_bits (sr_bits)
    );

    fpsu_summary u_summary (
        .sr_bits (sr_bits),
        .sr_next (sr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= RESET_VAL;
        end else if (ld_en) begin
            status_q <= ld_val;
        end else if (upd_valid) begin
            status_q <= sr_next;
        end
    end

    fpsu_report u_report (
        .clk       (clk),
        .rst       (rst),
        .upd       (upd),
        .record    (record),
        .mode      (exc_mode),
        .top_next  (sr_next[P_XS:CRF_LO]),
        .es_next   (sr_next[P_ES]),
        .crf_q     (crf_q),
        .crf_valid (crf_valid),
        .irq_req   (irq_req)
    );

    // R2: XS is never cleared by an update
    p_xs_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (upd && status_q[P_XS]) |=> status_q[P_XS]);

    // R3: IX is never cleared by an update
    p_ix_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (upd && status_q[P_IX]) |=> status_q[P_IX]);

    // R6: invalid summary agrees with cause bits after an update
    p_is_summary_r6: assert property (@(posedge clk) disable iff (rst)
        upd |=> (status_q[P_IS] == (|status_q[INV_HI:INV_LO])));

    // R7: enabled summary agrees with bits and enables after an update
    p_es_summary_r7: assert property (@(posedge clk) disable iff (rst)
        upd |=> (status_q[P_ES] == enabled_exc(status_q)));

    // R9: a request always reflects a set enabled summary
    p_irq_es_r9: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> status_q[P_ES]);

    // R11: load wins
    p_load_r11: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (status_q == $past(ld_val)));

    // R12: idle holds the word
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!upd_valid && !ld_en) |=> $stable(status_q));

endmodule

// File: tb/test_fpsu_status_unit.sv
module test_fpsu_status_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    typedef struct packed {
        logic [31:0] init;
        logic        ovf;
        logic        unf;
        logic        zdiv;
        logic        inx;
        logic        rnd;
        logic        finx;
        logic [5:0]  inv;
        logic        cls_we;
        logic [4:0]  cls;
        logic        cc_we;
        logic [3:0]  cc;
        logic        rec;
        logic [1:0]  mode;
    } vec_t;

    // init, ovf, unf, zdiv, inx, rnd, finx, inv, cls_we, cls, cc_we, cc, rec, mode
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0, 5'h00, 1'b0, 4'h0, 1'b1, 2'b00},
        '{32'h0000_0040, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0, 5'h00, 1'b0, 4'h0, 1'b1, 2'b01},
        '{32'h0200_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0, 5'h00, 1'b0, 4'h0, 1'b1, 2'b00},
        '{32'h1000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0, 5'h00, 1'b0, 4'h0, 1'b1, 2'b11},
        '{32'h0100_0080, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h05, 1'b0, 5'h00, 1'b0, 4'h0, 1'b1, 2'b10},
        '{32'h0000_0008, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'h00, 1'b0, 5'h00, 1'b0, 4'h0, 1'b0, 2'b11},
        '{32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b1, 5'h15, 1'b1, 4'h3, 1'b0, 2'b00},
        '{32'h0001_F000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0, 5'h00, 1'b1, 4'hA, 1'b0, 2'b00},
        '{32'h0000_0030, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0, 5'h00, 1'b0, 4'h0, 1'b1, 2'b00},
        '{32'h2000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'h00, 1'b0, 5'h00, 1'b0, 4'h0, 1'b1, 2'b00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_valid = 1'b0;
    logic        cond_ovf = 1'b0, cond_unf = 1'b0, cond_zdiv = 1'b0;
    logic        cond_inexact = 1'b0, cond_rnd = 1'b0, cond_finx = 1'b0;
    logic [5:0]  inv_cause = '0;
    logic        class_we = 1'b0;
    logic [4:0]  class_val = '0;
    logic        cc_we = 1'b0;
    logic [3:0]  cc_val = '0;
    logic        record = 1'b0;
    logic [1:0]  exc_mode = '0;
    logic        ld_en = 1'b0;
    logic [31:0] ld_val = '0;
    logic [31:0] status_q;
    logic [3:0]  crf_q;
    logic        crf_valid;
    logic        irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpsu_status_unit i_fpsu_status_unit (
        .clk(clk), .rst(rst), .upd_valid(upd_valid),
        .cond_ovf(cond_ovf), .cond_unf(cond_unf), .cond_zdiv(cond_zdiv),
        .cond_inexact(cond_inexact), .cond_rnd(cond_rnd), .cond_finx(cond_finx),
        .inv_cause(inv_cause), .class_we(class_we), .class_val(class_val),
        .cc_we(cc_we), .cc_val(cc_val), .record(record), .exc_mode(exc_mode),
        .ld_en(ld_en), .ld_val(ld_val), .status_q(status_q), .crf_q(crf_q),
        .crf_valid(crf_valid), .irq_req(irq_req)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] c, input vec_t v);
        logic [31:0] n;
        n = c;
        if (v.ovf) begin n[28] = 1'b1; n[31] = 1'b1; end else n[28] = 1'b0;
        if (v.unf) begin n[27] = 1'b1; n[31] = 1'b1; end else n[27] = 1'b0;
        if (v.zdiv) begin n[26] = 1'b1; n[31] = 1'b1; end else n[26] = 1'b0;
        if (v.inx) begin n[25] = 1'b1; n[31] = 1'b1; end
        n[18] = v.rnd;
        n[17] = v.finx;
        n[24:19] = n[24:19] | v.inv;
        if (v.inv != 0) n[31] = 1'b1;
        if (v.cls_we) n[16:12] = v.cls;
        else if (v.cc_we) n[15:12] = v.cc;
        n[29] = |n[24:19];
        n[30] = (n[29] & n[7]) | (n[28] & n[6]) | (n[27] & n[5]) |
                (n[26] & n[4]) | (n[25] & n[3]);
        return n;
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            0: return "R2";
            1: return "R7";
            2: return "R3";
            3: return "R2";
            4: return "R5";
            5: return "R4";
            6: return "R10";
            7: return "R10";
            8: return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic load(input logic [31:0] w);
        @(negedge clk);
        ld_en = 1'b1; ld_val = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic drive(input vec_t v, input logic ld, input logic [31:0] w);
        @(negedge clk);
        upd_valid = 1'b1;
        cond_ovf = v.ovf; cond_unf = v.unf; cond_zdiv = v.zdiv;
        cond_inexact = v.inx; cond_rnd = v.rnd; cond_finx = v.finx;
        inv_cause = v.inv; class_we = v.cls_we; class_val = v.cls;
        cc_we = v.cc_we; cc_val = v.cc; record = v.rec; exc_mode = v.mode;
        ld_en = ld; ld_val = w;
        @(negedge clk);
        upd_valid = 1'b0; ld_en = 1'b0;
        cond_ovf = 1'b0; cond_unf = 1'b0; cond_zdiv = 1'b0;
        cond_inexact = 1'b0; cond_rnd = 1'b0; cond_finx = 1'b0;
        inv_cause = '0; class_we = 1'b0; cc_we = 1'b0; record = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0]  crf_exp;
        logic [31:0] exp_w;
        vec_t        v;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "status", status_q, 32'h0);
        check("R1", "crf", {28'h0, crf_q}, 32'h0);
        check("R1", "crf_valid", {31'h0, crf_valid}, 32'h0);
        check("R1", "irq", {31'h0, irq_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "status after release", status_q, 32'h0);
        crf_exp = 4'h0;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            load(v.init);
            drive(v, 1'b0, 32'h0);
            exp_w = model(v.init, v);
            if (v.rec) crf_exp = exp_w[31:28];
            check(tag_of(i), "status", status_q, exp_w);
            check("R8", "crf", {28'h0, crf_q}, {28'h0, crf_exp});
            check("R8", "crf_valid", {31'h0, crf_valid}, {31'h0, v.rec});
            check("R9", "irq", {31'h0, irq_req},
                  {31'h0, exp_w[30] & (|v.mode)});
        end

        // directed corner values
        // R4: FI alone leaves IX clear, ES stays 0 despite IX enable
        load(32'h0000_0008);
        v = VECS[5];
        drive(v, 1'b0, 32'h0);
        check("R4", "fi without ix", status_q, 32'h0006_0008);

        // R9: request lasts one cycle
        load(32'h0000_0040);
        v = VECS[1];
        drive(v, 1'b0, 32'h0);
        check("R9", "irq raised", {31'h0, irq_req}, 32'h1);
        @(negedge clk);
        check("R9", "irq one cycle", {31'h0, irq_req}, 32'h0);
        check("R8", "crf_valid one cycle", {31'h0, crf_valid}, 32'h0);

        // R9: enabled exception but both mode bits clear
        load(32'h0000_0040);
        v = VECS[1]; v.mode = 2'b00;
        drive(v, 1'b0, 32'h0);
        check("R9", "irq masked by mode", {31'h0, irq_req}, 32'h0);
        check("R7", "es still set", {31'h0, status_q[30]}, 32'h1);

        // R8: update without record keeps the field
        crf_exp = crf_q;
        load(32'h0000_0000);
        v = VECS[0]; v.rec = 1'b0;
        drive(v, 1'b0, 32'h0);
        check("R8", "crf held", {28'h0, crf_q}, {28'h0, crf_exp});
        check("R2", "ovf set xs", status_q, 32'h9000_0000);

        // R11: load overrides simultaneous update
        v = VECS[8];
        drive(v, 1'b1, 32'h0123_4567);
        check("R11", "load wins", status_q, 32'h0123_4567);
        check("R11", "no crf pulse", {31'h0, crf_valid}, 32'h0);

        // R12: idle cycles with conditions toggling hold the word
        @(negedge clk);
        cond_ovf = 1'b1; inv_cause = 6'h3F; class_we = 1'b1; class_val = 5'h1F;
        repeat (3) @(negedge clk);
        check("R12", "hold", status_q, 32'h0123_4567);
        cond_ovf = 1'b0; inv_cause = '0; class_we = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule